// File: doc/BRIEF.md
# Bit-Maskable Synchronous Single-Port RAM

This block is a synthesizable behavioural model of a small single-port synchronous memory: 64 words of 16 bits, with separate input and output data buses. One control line picks read (high) or write (low). A 16-bit mask chooses which data bits a write stores. All controls are sampled on the rising clock edge. The registered output shows the addressed word after a read and the incoming data after a write. In every other case it keeps its previous value.

Two array-level controls sit alongside the normal access path. The row-disable control blocks every access. The all-rows control turns a write into a broadcast of the masked data to every address. A chip enable and a test-mode inhibit gate all activity. Scan access is left to a wrapper block.

Each cycle is decoded into one of four named operations:
- `OP_NONE`: nothing happens.
- `OP_READ`: the addressed word is loaded into the output register.
- `OP_WRITE`: a masked write to one row, with the data passed through to the output.
- `OP_BCAST`: a masked write to all rows, with the data passed through to the output.

The output register moves to the value that the decoded operation selects, or holds when the operation is `OP_NONE`.

Top module: `bitmask_sp_ram`

## Requirements
- R1: While the active-low reset is asserted, and on its release, `do_o` is 16'h0000.
- R2: A read happens when `en_i`=1, `tm_i`=0, `wl_off_i`=0, `burn_i`=0 and `rd_wrn_i`=1. One clock later, `do_o` equals the word stored at `addr_i`, and the array is unchanged.
- R3: A write happens when `en_i`=1, `tm_i`=0, `wl_off_i`=0, `burn_i`=0 and `rd_wrn_i`=0. For the word at `addr_i`:
  - each bit i with `ben_i[i]`=1 takes `di_i[i]`;
  - each bit with `ben_i[i]`=0 keeps its old value.
- R4: One clock after any write (single-row or broadcast), `do_o` equals all 16 bits of `di_i`, whatever the mask.
- R5: When `en_i`=0 or `tm_i`=1, no word of the array changes and `do_o` holds its value.
- R6: A write with `ben_i`=16'h0000 leaves the addressed word unchanged, yet still presents `di_i` on `do_o`.
- R7: When `wl_off_i`=1 (with `en_i`=1 and `tm_i`=0), no word changes and `do_o` holds. This applies to reads, writes and writes with `burn_i`=1 alike.
- R8: With `burn_i`=1 and `wl_off_i`=0, a write applies the masked update of R3 to all 64 words. With `burn_i`=1 and `wl_off_i`=0, a read leaves `do_o` unchanged.
- R9: A read issued in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs sampled on rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| en_i | input | 1 | Chip enable, active high |
| tm_i | input | 1 | Test-mode inhibit; blocks all access when high |
| rd_wrn_i | input | 1 | 1 = read, 0 = write |
| wl_off_i | input | 1 | Row-disable; blocks all access when high |
| burn_i | input | 1 | All-rows control; turns a write into a broadcast |
| addr_i | input | 6 | Word address |
| ben_i | input | 16 | Per-bit write mask, active high |
| di_i | input | 16 | Write data |
| do_o | output | 16 | Registered read or write-through data |

## Verification
The checker tests several properties on every cycle:
- output hold while the block is disabled or inhibited;
- output hold under row-disable;
- output hold for a read with the all-rows control set;
- the full write-through value one clock after any write;
- the reset value.

Properties that depend on array contents can only be shown by the bench's scenarios, because they require knowing what was stored earlier. These are the read value, the per-bit merge, the zero-mask case, the broadcast to all rows and back-to-back read-after-write. The bench covers them with full address sweeps against a model array.

// File: rtl/bmram_pkg.sv
package bmram_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_BCAST = 2'd3
    } bmram_op_e;

endpackage

// File: rtl/bmram_decode.sv
module bmram_decode
    import bmram_pkg::*;
(
    input  logic      en_i,
    input  logic      tm_i,
    input  logic      rd_wrn_i,
    input  logic      wl_off_i,
    input  logic      burn_i,
    output bmram_op_e op_o
);

    logic access_ok;

    // An access needs the chip enabled, test mode off and the rows enabled.
    assign access_ok = en_i && !tm_i && !wl_off_i;

    always_comb begin
        op_o = OP_NONE;
        if (access_ok) begin
            unique case ({burn_i, rd_wrn_i})
                2'b00:   op_o = OP_WRITE;
                2'b01:   op_o = OP_READ;
                2'b10:   op_o = OP_BCAST;
                default: op_o = OP_NONE; // all rows on during a read: no capture
            endcase
        end
    end

endmodule

// File: rtl/bmram_array.sv
module bmram_array
    import bmram_pkg::*;
#(
    parameter int unsigned WORDS = 64,
    parameter int unsigned WIDTH = 16,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input  logic             clk_i,
    input  bmram_op_e        op_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] ben_i,
    input  logic [WIDTH-1:0] di_i,
    output logic [WIDTH-1:0] rd_data_o
);

    logic [WIDTH-1:0] mem [WORDS];
    logic [WORDS-1:0] row_we;

    for (genvar r = 0; r < WORDS; r++) begin : g_row_sel
        localparam logic [AW-1:0] ROW = AW'(r);
        assign row_we[r] = (op_i == OP_BCAST) ||
                           ((op_i == OP_WRITE) && (addr_i == ROW));
    end

    always_ff @(posedge clk_i) begin
        for (int r = 0; r < WORDS; r++) begin
            if (row_we[r]) begin
                mem[r] <= (mem[r] & ~ben_i) | (di_i & ben_i);
            end
        end
    end

    assign rd_data_o = mem[addr_i];

endmodule

// File: rtl/bmram_outreg.sv
module bmram_outreg
    import bmram_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  bmram_op_e        op_i,
    input  logic [WIDTH-1:0] rd_data_i,
    input  logic [WIDTH-1:0] di_i,
    output logic [WIDTH-1:0] do_o
);

    logic [WIDTH-1:0] do_q;
    logic [WIDTH-1:0] do_d;

    always_comb begin
        unique case (op_i)
            OP_READ:  do_d = rd_data_i;
            OP_WRITE,
            OP_BCAST: do_d = di_i;
            default:  do_d = do_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            do_q <= '0;
        end else begin
            do_q <= do_d;
        end
    end

    assign do_o = do_q;

endmodule

// File: rtl/bitmask_sp_ram.sv
module bitmask_sp_ram
    import bmram_pkg::*;
#(
    parameter int unsigned WORDS = 64,
    parameter int unsigned WIDTH = 16,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tm_i,
    input  logic             rd_wrn_i,
    input  logic             wl_off_i,
    input  logic             burn_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] ben_i,
    input  logic [WIDTH-1:0] di_i,
    output logic [WIDTH-1:0] do_o
);

    bmram_op_e        op;
    logic [WIDTH-1:0] rd_data;

    bmram_decode u_decode (
        .en_i    (en_i),
        .tm_i    (tm_i),
        .rd_wrn_i(rd_wrn_i),
        .wl_off_i(wl_off_i),
        .burn_i  (burn_i),
        .op_o    (op)
    );

    bmram_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_array (
        .clk_i    (clk_i),
        .op_i     (op),
        .addr_i   (addr_i),
        .ben_i    (ben_i),
        .di_i     (di_i),
        .rd_data_o(rd_data)
    );

    bmram_outreg #(.WIDTH(WIDTH)) u_outreg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .op_i     (op),
        .rd_data_i(rd_data),
        .di_i     (di_i),
        .do_o     (do_o)
    );

endmodule

// File: rtl/bmram_chk.sv
module bmram_chk #(
    parameter int unsigned WORDS = 64,
    parameter int unsigned WIDTH = 16,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             tm_i,
    input logic             rd_wrn_i,
    input logic             wl_off_i,
    input logic             burn_i,
    input logic [AW-1:0]    addr_i,
    input logic [WIDTH-1:0] ben_i,
    input logic [WIDTH-1:0] di_i,
    input logic [WIDTH-1:0] do_o
);

    always @(negedge clk_i) begin
        if (!rst_ni) begin
            AST_RESET_ZERO: assert (do_o == '0); // R1
        end
    end

    AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i || tm_i) |=> $stable(do_o)); // R5

    AST_WLOFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tm_i && wl_off_i) |=> $stable(do_o)); // R7

    AST_WRITE_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tm_i && !wl_off_i && !rd_wrn_i) |=> (do_o == $past(di_i))); // R4

    AST_BURN_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tm_i && !wl_off_i && burn_i && rd_wrn_i) |=> $stable(do_o)); // R8

endmodule

bind bitmask_sp_ram bmram_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tm_i    (tm_i),
    .rd_wrn_i(rd_wrn_i),
    .wl_off_i(wl_off_i),
    .burn_i  (burn_i),
    .addr_i  (addr_i),
    .ben_i   (ben_i),
    .di_i    (di_i),
    .do_o    (do_o)
);

// File: tb/bitmask_sp_ram_tb_top.sv
module bitmask_sp_ram_tb_top;

    localparam int WORDS = 64;
    localparam int WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             tm = 1'b0;
    logic             rd_wrn = 1'b1;
    logic             wl_off = 1'b0;
    logic             burn = 1'b0;
    logic [5:0]       addr = '0;
    logic [WIDTH-1:0] ben = '0;
    logic [WIDTH-1:0] di = '0;
    logic [WIDTH-1:0] dout;

    logic [WIDTH-1:0] model [WORDS];
    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bitmask_sp_ram dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .en_i    (en),
        .tm_i    (tm),
        .rd_wrn_i(rd_wrn),
        .wl_off_i(wl_off),
        .burn_i  (burn),
        .addr_i  (addr),
        .ben_i   (ben),
        .di_i    (di),
        .do_o    (dout)
    );

    task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle from a falling edge; return at the next falling edge.
    task automatic cyc(input logic e, input logic t, input logic rw, input logic wo,
                       input logic bi, input logic [5:0] a, input logic [WIDTH-1:0] m,
                       input logic [WIDTH-1:0] d);
        en = e; tm = t; rd_wrn = rw; wl_off = wo; burn = bi; addr = a; ben = m; di = d;
        @(negedge clk);
    endtask

    function automatic logic [WIDTH-1:0] pat(input int a);
        return WIDTH'((a * 16'h0101) ^ 16'hA5C3);
    endfunction

    task automatic read_all(input string req);
        for (int a = 0; a < WORDS; a++) begin
            cyc(1, 0, 1, 0, 0, 6'(a), '0, '0);
            check(req, dout, model[a]);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        logic [WIDTH-1:0] held;
        @(negedge clk);
        @(negedge clk);
        check("R1", dout, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", dout, 16'h0000);

        // Initialise the array with full-mask writes.
        for (int a = 0; a < WORDS; a++) begin
            cyc(1, 0, 0, 0, 0, 6'(a), 16'hFFFF, pat(a));
            model[a] = pat(a);
            check("R4", dout, pat(a));
        end
        read_all("R2");

        // Masked writes with varying masks.
        for (int a = 0; a < WORDS; a++) begin
            logic [WIDTH-1:0] m;
            logic [WIDTH-1:0] d;
            m = WIDTH'({a[5:0], ~a[5:0], a[3:0]});
            d = ~pat(a) ^ WIDTH'(a << 3);
            cyc(1, 0, 0, 0, 0, 6'(a), m, d);
            check("R4", dout, d);
            model[a] = (model[a] & ~m) | (d & m);
        end
        read_all("R3");

        // Zero-mask write.
        cyc(1, 0, 0, 0, 0, 6'd5, 16'h0000, 16'h5A5A);
        check("R6", dout, 16'h5A5A);
        cyc(1, 0, 1, 0, 0, 6'd5, '0, '0);
        check("R6", dout, model[5]);

        // Disabled and test-mode cycles.
        held = dout;
        cyc(0, 0, 0, 0, 0, 6'd7, 16'hFFFF, 16'hDEAD);
        check("R5", dout, held);
        cyc(1, 1, 0, 0, 0, 6'd7, 16'hFFFF, 16'hBEEF);
        check("R5", dout, held);
        cyc(1, 1, 1, 0, 0, 6'd8, '0, '0);
        check("R5", dout, held);
        cyc(0, 0, 1, 0, 0, 6'd8, '0, '0);
        check("R5", dout, held);
        cyc(1, 0, 1, 0, 0, 6'd7, '0, '0);
        check("R5", dout, model[7]);

        // Row-disable.
        held = dout;
        cyc(1, 0, 0, 1, 0, 6'd9, 16'hFFFF, 16'h1111);
        check("R7", dout, held);
        cyc(1, 0, 0, 1, 1, 6'd9, 16'hFFFF, 16'h2222);
        check("R7", dout, held);
        cyc(1, 0, 1, 1, 0, 6'd3, '0, '0);
        check("R7", dout, held);
        read_all("R7");

        // Broadcast write and all-rows read.
        cyc(1, 0, 0, 0, 1, 6'd0, 16'h00FF, 16'h1234);
        check("R8", dout, 16'h1234);
        for (int a = 0; a < WORDS; a++) model[a] = (model[a] & 16'hFF00) | 16'h0034;
        held = dout;
        cyc(1, 0, 1, 0, 1, 6'd2, '0, '0);
        check("R8", dout, held);
        read_all("R8");

        // Read immediately after write to the same address.
        cyc(1, 0, 0, 0, 0, 6'd9, 16'hF0F0, 16'hCAFE);
        model[9] = (model[9] & 16'h0F0F) | (16'hCAFE & 16'hF0F0);
        check("R4", dout, 16'hCAFE);
        cyc(1, 0, 1, 0, 0, 6'd9, '0, '0);
        check("R9", dout, model[9]);

        done = 1'b1;
        report();
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

endmodule